// File: doc/BRIEF.md
# Audio FIFO Error Flag Logic

This block sits between a processor bus and the serial side of an audio port. It holds two small word FIFOs. The bus fills the transmit FIFO and the serial side drains it. The serial side delivers each received word into a single holding register, and that register moves the word into the receive FIFO, which the bus then reads.

Around the FIFOs the block keeps three sticky error flags. Transmit overflow records a bus write that arrived with the transmit FIFO full. Receive underflow records a bus read of an empty receive FIFO. Receive overflow records a serial word that arrived while the holding register still held an earlier word that had not moved on. Each flag has its own enable bit. A flag is set whatever its enable is, and software clears it by writing a zero to it. A single interrupt line reports any flag whose enable is set.

Top module: `audio_fifo_err`

## Requirements
- R1: The transmit FIFO holds DEPTH (default 8) words in arrival order, and `tx_count` reads DEPTH when it is full.
- R2: A bus write while `tx_count` equals DEPTH sets flag bit 0 (transmit overflow) on the next edge. The written word is discarded, and the count and pointers stay as they were.
- R3: A bus read while `rx_count` is 0 sets flag bit 1 (receive underflow) on the next edge. The count and pointers stay as they were, and the data returned has no meaning.
- R4: A serial word arriving while the holding register is occupied and cannot move into a full receive FIFO sets flag bit 2 (receive overflow). The held word is replaced by the new one.
- R5: Every flag is set by its event whatever the value of its enable bit, and it stays set until it is cleared.
- R6: A flag-clear write (`stat_wr_en`) clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R7: If a set event and a zero-write to the same flag fall on the same edge, the flag ends up set.
- R8: `irq` is the OR over the three bits of (flag AND enable), registered, so it follows the flag and enable state with one cycle of delay.
- R9: A synchronous active-low reset clears the flags, the enables, `irq`, both counts and all pointers.
- R10: A received word passes from the holding register into the receive FIFO on the first edge at which the FIFO has room, and the bus reads the received words in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_en | input | 1 | Bus write to the transmit FIFO |
| tx_wr_data | input | W | Word written by the bus |
| tx_rd_en | input | 1 | Serial side takes the head transmit word |
| tx_rd_data | output | W | Head word of the transmit FIFO |
| tx_count | output | $clog2(DEPTH+1) | Words held in the transmit FIFO |
| rx_in_valid | input | 1 | Serial side delivers a received word |
| rx_in_data | input | W | Received word |
| rx_rd_en | input | 1 | Bus read from the receive FIFO |
| rx_rd_data | output | W | Head word of the receive FIFO |
| rx_count | output | $clog2(DEPTH+1) | Words held in the receive FIFO |
| stat_wr_en | input | 1 | Flag-clear write strobe |
| stat_wr_data | input | 3 | Per-flag keep mask (0 clears) |
| en_wr_en | input | 1 | Enable register write strobe |
| en_wr_data | input | 3 | New enable bits |
| err_flags | output | 3 | Flags: bit 0 tx overflow, bit 1 rx underflow, bit 2 rx overflow |
| err_en | output | 3 | Enable bits, same order as the flags |
| irq | output | 1 | Combined interrupt |

## Verification
The clear-write and stickiness properties assume that, on a cycle with no bus write, no bus read and no serial arrival, nothing else can set a flag, so they only judge cycles that are quiet in that sense. The bench drives every input one nanosecond after a rising edge and holds it for a whole cycle, so each event is seen by exactly one edge. It isolates each error case (overflow, underflow, overrun, collision of a set and a clear), and a monitor compares the data at both FIFO heads against the queues the driver filled.

// File: rtl/audio_err_pkg.sv
// Package: shared flag positions and counts for the audio FIFO error block.
// Assumes: the flag positions are visible to software and must stay fixed.
package audio_err_pkg;
    localparam int NUM_ERR = 3;
    localparam int ERR_TX_OVF = 0;
    localparam int ERR_RX_UDF = 1;
    localparam int ERR_RX_OVF = 2;
endpackage

// File: rtl/afe_sync_fifo.sv
// Module: single-clock word FIFO with a combinational head word.
// What it does: stores up to DEPTH words. A push while full or a pop while
// empty is blocked and reported on push_drop or pop_drop.
// Assumes: DEPTH >= 2. The storage itself is not reset.
module afe_sync_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_drop,
    output logic          pop_drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Qualify requests against the occupancy.
    always_comb begin
        full      = (count == CW'(DEPTH));
        do_push   = push && !full;
        do_pop    = pop && (count != '0);
        push_drop = push && full;
        pop_drop  = pop && (count == '0);
        pop_data  = mem[rd_ptr];
    end

    // Write accepted words into storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/afe_rx_hold.sv
// Module: receive holding register in front of the receive FIFO.
// What it does: catches each serial word and moves it into the FIFO when
// there is room. An arrival while the word cannot move overwrites it and
// raises overrun.
// Assumes: fifo_full is the FIFO's occupancy as seen in the same cycle.
module afe_rx_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         fifo_full,
    output logic [W-1:0] hold_data,
    output logic         xfer,
    output logic         overrun
);
    logic hold_valid;

    // Decide transfer and overrun for this cycle.
    always_comb begin
        xfer    = hold_valid && !fifo_full;
        overrun = in_valid && hold_valid && !xfer;
    end

    // Load new arrivals, or empty the register after a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (in_valid) begin
            hold_valid <= 1'b1;
            hold_data  <= in_data;
        end else if (xfer) begin
            hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/afe_err_flags.sv
// Module: sticky error flags, enable bits and the registered interrupt.
// What it does: set_vec sets flags regardless of enables. A clear write
// drops each flag whose data bit is 0. A set wins over a clear on the same edge.
// Assumes: set_vec is a single-cycle pulse per event.
module afe_err_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic         en_wr,
    input  logic [N-1:0] en_data,
    output logic [N-1:0] flags,
    output logic [N-1:0] en,
    output logic         irq
);
    logic [N-1:0] keep_mask;

    // Bits to keep: all of them unless a clear write is present.
    always_comb keep_mask = clr_wr ? clr_data : '1;

    // Flag, enable and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= set_vec | (flags & keep_mask);
            if (en_wr) en <= en_data;
            irq   <= |(flags & en);
        end
    end
endmodule

// File: rtl/audio_fifo_err.sv
// Module: top of the audio FIFO error block.
// What it does: transmit FIFO (bus in, serial out), receive holding register
// and receive FIFO (serial in, bus out), plus the three sticky error flags.
// Assumes: one bus access of each kind per cycle at most.
module audio_fifo_err #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NE   = audio_err_pkg::NUM_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr_en,
    input  logic [W-1:0]  tx_wr_data,
    input  logic          tx_rd_en,
    output logic [W-1:0]  tx_rd_data,
    output logic [CW-1:0] tx_count,
    input  logic          rx_in_valid,
    input  logic [W-1:0]  rx_in_data,
    input  logic          rx_rd_en,
    output logic [W-1:0]  rx_rd_data,
    output logic [CW-1:0] rx_count,
    input  logic          stat_wr_en,
    input  logic [NE-1:0] stat_wr_data,
    input  logic          en_wr_en,
    input  logic [NE-1:0] en_wr_data,
    output logic [NE-1:0] err_flags,
    output logic [NE-1:0] err_en,
    output logic          irq
);
    import audio_err_pkg::*;

    logic          tx_full, tx_ovf, tx_udf_unused;
    logic          rx_full, rx_udf, rx_ovf_unused;
    logic          hold_xfer, hold_ovr;
    logic [W-1:0]  hold_word;
    logic [NE-1:0] set_vec;

    afe_sync_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_rd_en),
        .pop_data  (tx_rd_data),
        .count     (tx_count),
        .full      (tx_full),
        .push_drop (tx_ovf),
        .pop_drop  (tx_udf_unused)
    );

    afe_rx_hold #(.W(W)) u_rx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .fifo_full (rx_full),
        .hold_data (hold_word),
        .xfer      (hold_xfer),
        .overrun   (hold_ovr)
    );

    afe_sync_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (hold_xfer),
        .push_data (hold_word),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .count     (rx_count),
        .full      (rx_full),
        .push_drop (rx_ovf_unused),
        .pop_drop  (rx_udf)
    );

    // Gather the error events into flag positions.
    always_comb begin
        set_vec             = '0;
        set_vec[ERR_TX_OVF] = tx_ovf;
        set_vec[ERR_RX_UDF] = rx_udf;
        set_vec[ERR_RX_OVF] = hold_ovr;
    end

    afe_err_flags #(.N(NE)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (stat_wr_en),
        .clr_data (stat_wr_data),
        .en_wr    (en_wr_en),
        .en_data  (en_wr_data),
        .flags    (err_flags),
        .en       (err_en),
        .irq      (irq)
    );
endmodule

// File: rtl/audio_fifo_err_chk.sv
// Module: property checker bound to audio_fifo_err.
// Assumes: observes only the top-level ports. Quiet cycles (no bus access,
// no serial arrival) cannot set a flag.
module audio_fifo_err_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_wr_en,
    input logic          tx_rd_en,
    input logic [CW-1:0] tx_count,
    input logic          rx_in_valid,
    input logic          rx_rd_en,
    input logic [CW-1:0] rx_count,
    input logic          stat_wr_en,
    input logic [2:0]    stat_wr_data,
    input logic [2:0]    err_flags,
    input logic [2:0]    err_en,
    input logic          irq
);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    assert_tx_ovf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && tx_count == CW'(DEPTH)) |=> err_flags[0]);

    assert_tx_ovf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && !tx_rd_en && tx_count == CW'(DEPTH)) |=> (tx_count == CW'(DEPTH)));

    assert_rx_udf_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_count == '0) |=> err_flags[1]);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr_en |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_clear_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !tx_wr_en && !rx_rd_en && !rx_in_valid)
        |=> (err_flags == ($past(err_flags) & $past(stat_wr_data))));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(err_flags) & $past(err_en))));
endmodule

bind audio_fifo_err audio_fifo_err_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_wr_en     (tx_wr_en),
    .tx_rd_en     (tx_rd_en),
    .tx_count     (tx_count),
    .rx_in_valid  (rx_in_valid),
    .rx_rd_en     (rx_rd_en),
    .rx_count     (rx_count),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .err_flags    (err_flags),
    .err_en       (err_en),
    .irq          (irq)
);

// File: tb/tb_audio_fifo_err.sv
`timescale 1ns/1ps
module tb_audio_fifo_err;
    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_wr_en = 1'b0, tx_rd_en = 1'b0;
    logic [W-1:0]  tx_wr_data = '0, tx_rd_data;
    logic [CW-1:0] tx_count, rx_count;
    logic          rx_in_valid = 1'b0, rx_rd_en = 1'b0;
    logic [W-1:0]  rx_in_data = '0, rx_rd_data;
    logic          stat_wr_en = 1'b0, en_wr_en = 1'b0;
    logic [2:0]    stat_wr_data = '0, en_wr_data = '0;
    logic [2:0]    err_flags, err_en;
    logic          irq;

    int tests = 0, fails = 0;
    logic [W-1:0] exp_tx[$];
    logic [W-1:0] exp_rx[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    audio_fifo_err #(.W(W), .DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        tx_wr_en = 0; tx_rd_en = 0; rx_in_valid = 0; rx_rd_en = 0;
        stat_wr_en = 0; en_wr_en = 0;
    endtask

    // Driver: bus write of a transmit word, expected word queued if it fits.
    task automatic bus_tx_write(input logic [W-1:0] d, input bit expect_keep);
        tx_wr_en = 1; tx_wr_data = d;
        if (expect_keep) exp_tx.push_back(d);
        step(); idle();
    endtask

    // Monitor: compare FIFO head words against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && tx_rd_en && tx_count != '0) begin
            if (exp_tx.size() == 0) chk("R1 tx extra word", tx_rd_data, 'x);
            else chk("R1 tx order", tx_rd_data, exp_tx.pop_front());
        end
        if (rst_n && rx_rd_en && rx_count != '0) begin
            if (exp_rx.size() == 0) chk("R10 rx extra word", rx_rd_data, 'x);
            else chk("R10 rx order", rx_rd_data, exp_rx.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R9: reset state
        chk("R9 tx_count", tx_count, 0);
        chk("R9 rx_count", rx_count, 0);
        chk("R9 flags", err_flags, 0);
        chk("R9 en", err_en, 0);
        chk("R9 irq", irq, 0);
        rst_n = 1; step();

        // R1: fill transmit FIFO
        for (int i = 0; i < DEPTH; i++) bus_tx_write(16'hA000 + 16'(i), 1'b1);
        chk("R1 full count", tx_count, DEPTH);
        chk("R1 no flag", err_flags, 0);
        // R2 and R5: overflow with enables off
        bus_tx_write(16'hDEAD, 1'b0);
        chk("R2 tx ovf flag", err_flags, 3'b001);
        chk("R2 count kept", tx_count, DEPTH);
        chk("R5 irq off with en 0", irq, 0);
        step();
        chk("R5 flag stays", err_flags, 3'b001);
        // drain
        for (int i = 0; i < DEPTH; i++) begin tx_rd_en = 1; step(); end
        idle();
        chk("R2 lost word absent", tx_count, 0);
        chk("R2 queue drained", exp_tx.size(), 0);

        // R3: read empty receive FIFO
        rx_rd_en = 1; step(); idle();
        chk("R3 udf flag", err_flags, 3'b011);
        chk("R3 count kept", rx_count, 0);

        // R8: enable and watch irq
        en_wr_en = 1; en_wr_data = 3'b111; step(); idle();
        chk("R8 en", err_en, 3'b111);
        chk("R8 irq not yet", irq, 0);
        step();
        chk("R8 irq up", irq, 1);

        // R6: ones keep, zeros clear
        stat_wr_en = 1; stat_wr_data = 3'b111; step(); idle();
        chk("R6 ones keep", err_flags, 3'b011);
        stat_wr_en = 1; stat_wr_data = 3'b110; step(); idle();
        chk("R6 clear bit0", err_flags, 3'b010);
        stat_wr_en = 1; stat_wr_data = 3'b101; step(); idle();
        chk("R6 clear bit1", err_flags, 3'b000);
        step();
        chk("R8 irq down", irq, 0);

        // R4 and R10: ten serial words, the tenth overruns the ninth
        for (int i = 1; i <= 10; i++) begin
            rx_in_valid = 1; rx_in_data = 16'h5000 + 16'(i);
            if (i <= 8) exp_rx.push_back(16'h5000 + 16'(i));
            if (i == 9) chk("R4 no early ovf", err_flags[2], 0);
            step();
        end
        idle();
        exp_rx.push_back(16'h500A);
        chk("R4 rx ovf flag", err_flags, 3'b100);
        chk("R10 rx full", rx_count, DEPTH);
        for (int i = 0; i < DEPTH + 1; i++) begin rx_rd_en = 1; step(); end
        idle();
        chk("R4 newer word kept", exp_rx.size(), 0);
        chk("R10 rx empty", rx_count, 0);

        // R7: underflow and zero-write on the same edge
        rx_rd_en = 1; stat_wr_en = 1; stat_wr_data = 3'b000; step(); idle();
        chk("R7 set wins", err_flags, 3'b010);

        // R9: mid-run reset
        bus_tx_write(16'h1111, 1'b1);
        bus_tx_write(16'h2222, 1'b1);
        rst_n = 0; step(); rst_n = 1;
        exp_tx.delete();
        chk("R9 tx_count mid", tx_count, 0);
        chk("R9 flags mid", err_flags, 0);
        chk("R9 en mid", err_en, 0);
        chk("R9 irq mid", irq, 0);
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule